// File: doc/BRIEF.md
# SPI Client Word Packer

This block is the data path of an SPI client that moves data to and from the core 32 bits at a time. Eight-bit characters arriving on the serial input are packed four to a word, and words written by the core are unpacked into bytes and shifted out on the serial output. An optional frame length makes a group of bytes a unit. When that group is not a multiple of four, the group ends with a short word. Frames that stop before the group is complete are reported as a length error, and the leftover bytes go on into the next frame.

The core side is a register-style port. A write strobe loads a one-word transmit holding register. A read-acknowledge strobe frees the receive word register. Three flags go with the port: a word-ready flag, a holding-empty flag and a transmit-done flag. An optional address mode compares the first byte of each frame with a programmed address. On a match, the address byte goes into lane 0 and data fills the lanes after it. On a mismatch, the whole frame is ignored. The serial inputs are oversampled by the core clock through synchronizer stages.

Top module: `spi32_client_packer`

## Requirements
- R1: While `ss_n` is low, `mosi` is sampled on each rising `sck` edge and `miso` presents each byte most significant bit first. The first byte of a word sits in bits 7:0 (lane 0) and the fourth in bits 31:24 (lane 3).
- R2: After every fourth received byte, `rxc` rises and `rd_data` holds the word with `rd_cnt` = 4.
- R3: With `len_en` = 1 and `len_value` in 1..255, the byte that completes the length ends the current word early. `rxc` rises, `rd_cnt` = `len_value` mod 4 (4 when that is 0), and the unused upper lanes read 0.
- R4: When the length completes, the length count, the receive lane and the transmit lane all return to 0. Any transmit word in use is dropped, so the next byte starts lane 0 of the next word.
- R5: When `ss_n` rises with `len_en` = 1 and a length partly done, `len_err` is set. It stays set until a `len_err_clr` pulse. The rest of the length continues in the next frame.
- R6: With `len_en` = 0, a partial receive or transmit word carries over into the next frame.
- R7: With `rx_en` = 0, no word is delivered, but the length still counts one per eight `sck` rising edges.
- R8: With `addr_mode` = 1, the first byte of a frame is compared with `addr_value`. On a match it is stored in lane 0, any earlier partial word is discarded, and data follows in lane 1 upward. On a mismatch the frame is ignored: no word, no length count, no transmit lane advance, and `miso` low after the address byte.
- R9: `dre` is high while the holding register is empty. A write while `dre` is low is ignored. `dre` returns high once the held word moves into the shift word. `txc` rises when a word finishes with the holding register empty, and a write clears it.
- R10: When no transmit word is present, `miso` sends 0x00 bytes and the transmit lane does not advance.
- R11: `en` = 0 flushes the receive packer, the transmit holding and shift words, the counters, `rxc` and `txc`. It leaves `len_err` unchanged.
- R12: After reset: `dre` = 1, and `rxc`, `txc`, `len_err` and `miso` are 0.
- R13: A `rd_ack` pulse clears `rxc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low flushes the data path |
| rx_en | input | 1 | Store received bytes |
| len_en | input | 1 | Enable the frame length counter |
| len_value | input | LEN_W | Bytes per length, 1..255 |
| addr_mode | input | 1 | Enable first-byte address compare |
| addr_value | input | BYTE_W | Address to match |
| wr_valid | input | 1 | Transmit word write strobe |
| wr_data | input | WORD_BYTES*BYTE_W | Transmit word |
| rd_ack | input | 1 | Receive word read acknowledge |
| rd_data | output | WORD_BYTES*BYTE_W | Received word |
| rd_cnt | output | $clog2(WORD_BYTES+1) | Valid bytes in rd_data |
| rxc | output | 1 | Received word ready |
| dre | output | 1 | Transmit holding register empty |
| txc | output | 1 | Transmit finished, nothing queued |
| len_err | output | 1 | Sticky length error |
| len_err_clr | input | 1 | Clear the length error |
| sck | input | 1 | Serial clock from the host |
| ss_n | input | 1 | Active-low client select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |

## Verification
The assertions assume that `sck` is slow compared with `clk`, with each level held for several core cycles, so that two rising edges never fall in adjacent cycles. They also assume that `len_value`, `len_en` and `addr_mode` change only between frames. The stimulus keeps `sck` at eight core cycles per level, and it changes the configuration only while `ss_n` is high and any length is complete. Inputs change on the falling core clock edge, away from the sampling edge.

// File: rtl/spi32_pkg.sv
package spi32_pkg;
  localparam int DEF_BYTE_W     = 8;
  localparam int DEF_WORD_BYTES = 4;
  localparam int DEF_LEN_W      = 8;
  localparam int DEF_SYNC       = 2;
endpackage

// File: rtl/spi32_serial.sv
module spi32_serial
  import spi32_pkg::*;
#(
  parameter int BYTE_W      = DEF_BYTE_W,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_mute,
  output logic              byte_evt,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_first,
  output logic              frame_start,
  output logic              frame_end,
  output logic              miso
);
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] TOP_BIT = BC_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sck_sr, ss_sr, mosi_sr;
  logic sck_prev, ss_prev;
  logic sck_s, ss_s, mosi_s;
  logic active, rise, last_bit;
  logic [BC_W-1:0]   bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic              first_pend;

  assign sck_s  = sck_sr[SYNC_STAGES-1];
  assign ss_s   = ss_sr[SYNC_STAGES-1];
  assign mosi_s = mosi_sr[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sr   <= '0;
      ss_sr    <= '1;
      mosi_sr  <= '0;
      sck_prev <= 1'b0;
      ss_prev  <= 1'b1;
    end else begin
      sck_sr   <= {sck_sr[SYNC_STAGES-2:0], sck};
      ss_sr    <= {ss_sr[SYNC_STAGES-2:0], ss_n};
      mosi_sr  <= {mosi_sr[SYNC_STAGES-2:0], mosi};
      sck_prev <= sck_s;
      ss_prev  <= ss_s;
    end
  end

  assign active      = en && !ss_s;
  assign frame_start = en && ss_prev && !ss_s;
  assign frame_end   = en && !ss_prev && ss_s;
  assign rise        = active && sck_s && !sck_prev;
  assign last_bit    = (bit_cnt == TOP_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      byte_evt   <= 1'b0;
      byte_data  <= '0;
      byte_first <= 1'b0;
      first_pend <= 1'b0;
      miso       <= 1'b0;
    end else begin
      byte_evt <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
      end else if (rise) begin
        shreg <= {shreg[BYTE_W-3:0], mosi_s};
        if (last_bit) begin
          bit_cnt    <= '0;
          byte_evt   <= 1'b1;
          byte_data  <= {shreg, mosi_s};
          byte_first <= first_pend;
          first_pend <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (frame_start) first_pend <= 1'b1;
      miso <= (active && !tx_mute) ? tx_byte[TOP_BIT - bit_cnt] : 1'b0;
    end
  end

  // R1: bit position restarts whenever the client is not selected
  a_r1_idle_restart: assert property (@(posedge clk) disable iff (rst)
    !active |=> (bit_cnt == '0));
  // R1: a byte takes several sck edges, so completions never touch
  a_r1_evt_spaced: assert property (@(posedge clk) disable iff (rst)
    byte_evt |=> !byte_evt);
endmodule

// File: rtl/spi32_len.sv
module spi32_len
  import spi32_pkg::*;
#(
  parameter int LEN_W = DEF_LEN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             len_en,
  input  logic [LEN_W-1:0] len_value,
  input  logic             evt,
  input  logic             frame_end,
  input  logic             err_clr,
  output logic             len_hit,
  output logic             len_err
);
  logic [LEN_W-1:0] cnt;

  assign len_hit = evt && len_en && (len_value != '0) && (cnt + 1'b1 == len_value);

  always_ff @(posedge clk) begin
    if (rst || flush || !len_en) cnt <= '0;
    else if (len_hit)            cnt <= '0;
    else if (evt)                cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                      len_err <= 1'b0;
    else if (frame_end && len_en && cnt != '0)    len_err <= 1'b1;
    else if (err_clr)                             len_err <= 1'b0;
  end

  // R4: completing a length returns the count to zero
  a_r4_hit_clears: assert property (@(posedge clk) disable iff (rst)
    len_hit |=> (cnt == '0));
  // R5: the error bit holds until cleared
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    len_err && !err_clr |=> len_err);
endmodule

// File: rtl/spi32_rx_pack.sv
module spi32_rx_pack
  import spi32_pkg::*;
#(
  parameter int BYTES  = DEF_WORD_BYTES,
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    evt,
  input  logic [BYTE_W-1:0]       data,
  input  logic                    first,
  input  logic                    store_en,
  input  logic                    len_hit,
  input  logic                    rd_ack,
  output logic [BYTES*BYTE_W-1:0] rd_data,
  output logic [$clog2(BYTES+1)-1:0] rd_cnt,
  output logic                    rx_valid
);
  localparam int LANE_W = $clog2(BYTES);
  localparam int CNT_W  = $clog2(BYTES + 1);
  localparam int WORD_W = BYTES * BYTE_W;

  logic [WORD_W-1:0] acc, acc_next;
  logic [LANE_W-1:0] lane, lane_use;
  logic              push;

  assign lane_use = first ? '0 : lane;
  assign push     = evt && store_en && ((lane_use == LANE_W'(BYTES - 1)) || len_hit);

  always_comb begin
    for (int i = 0; i < BYTES; i++) begin
      if (LANE_W'(i) == lane_use) acc_next[i*BYTE_W +: BYTE_W] = data;
      else if (first)             acc_next[i*BYTE_W +: BYTE_W] = '0;
      else                        acc_next[i*BYTE_W +: BYTE_W] = acc[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc      <= '0;
      lane     <= '0;
      rd_data  <= '0;
      rd_cnt   <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (rd_ack) rx_valid <= 1'b0;
      if (evt && store_en) begin
        if (push) begin
          rd_data  <= acc_next;
          rd_cnt   <= CNT_W'(lane_use) + 1'b1;
          rx_valid <= 1'b1;
          acc      <= '0;
          lane     <= '0;
        end else begin
          acc  <= acc_next;
          lane <= lane_use + 1'b1;
        end
      end else if (evt && len_hit) begin
        acc  <= '0;
        lane <= '0;
      end
    end
  end

  // R2: a delivered word always carries between one and four bytes
  a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rd_cnt != '0) && (rd_cnt <= CNT_W'(BYTES)));
  // R13: acknowledge frees the word register when nothing new arrives
  a_r13_ack_clears: assert property (@(posedge clk) disable iff (rst)
    rd_ack && !evt && !flush |=> !rx_valid);
endmodule

// File: rtl/spi32_tx_unpack.sv
module spi32_tx_unpack
  import spi32_pkg::*;
#(
  parameter int BYTES  = DEF_WORD_BYTES,
  parameter int BYTE_W = DEF_BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic                    wr_valid,
  input  logic [BYTES*BYTE_W-1:0] wr_data,
  input  logic                    evt,
  input  logic                    len_hit,
  output logic [BYTE_W-1:0]       tx_byte,
  output logic                    dre,
  output logic                    txc
);
  localparam int LANE_W = $clog2(BYTES);
  localparam int WORD_W = BYTES * BYTE_W;

  logic [WORD_W-1:0] hold, word;
  logic              hold_v, word_v;
  logic [LANE_W-1:0] lane;
  logic              wr_acc, word_done, load;

  assign wr_acc    = wr_valid && !hold_v;
  assign word_done = evt && word_v && ((lane == LANE_W'(BYTES - 1)) || len_hit);
  assign load      = hold_v && (!word_v || word_done);
  assign tx_byte   = word_v ? word[int'(lane)*BYTE_W +: BYTE_W] : '0;
  assign dre       = !hold_v;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hold   <= '0;
      word   <= '0;
      hold_v <= 1'b0;
      word_v <= 1'b0;
      lane   <= '0;
      txc    <= 1'b0;
    end else begin
      if (wr_acc) begin
        hold   <= wr_data;
        hold_v <= 1'b1;
      end
      if (load) begin
        word   <= hold;
        word_v <= 1'b1;
        hold_v <= 1'b0;
        lane   <= '0;
      end else if (word_done) begin
        word_v <= 1'b0;
        lane   <= '0;
      end else if (evt && word_v) begin
        lane <= lane + 1'b1;
      end
      if (wr_acc)                      txc <= 1'b0;
      else if (word_done && !hold_v)   txc <= 1'b1;
    end
  end

  // R9: an accepted write fills the holding register on the next cycle
  a_r9_write_holds: assert property (@(posedge clk) disable iff (rst)
    wr_valid && dre && !flush |=> !dre);
  // R9: transmit-done is only reported with nothing left to send
  a_r9_txc_empty: assert property (@(posedge clk) disable iff (rst)
    txc |-> dre);
endmodule

// File: rtl/spi32_client_packer.sv
module spi32_client_packer
  import spi32_pkg::*;
#(
  parameter int BYTE_W      = DEF_BYTE_W,
  parameter int WORD_BYTES  = DEF_WORD_BYTES,
  parameter int LEN_W       = DEF_LEN_W,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              en,
  input  logic                              rx_en,
  input  logic                              len_en,
  input  logic [LEN_W-1:0]                  len_value,
  input  logic                              addr_mode,
  input  logic [BYTE_W-1:0]                 addr_value,
  input  logic                              wr_valid,
  input  logic [WORD_BYTES*BYTE_W-1:0]      wr_data,
  input  logic                              rd_ack,
  output logic [WORD_BYTES*BYTE_W-1:0]      rd_data,
  output logic [$clog2(WORD_BYTES+1)-1:0]   rd_cnt,
  output logic                              rxc,
  output logic                              dre,
  output logic                              txc,
  output logic                              len_err,
  input  logic                              len_err_clr,
  input  logic                              sck,
  input  logic                              ss_n,
  input  logic                              mosi,
  output logic                              miso
);
  logic              flush;
  logic              byte_evt, byte_first, frame_start, frame_end;
  logic [BYTE_W-1:0] byte_data, tx_byte;
  logic              drop, mismatch, evt_eff, first_eff, len_hit;

  assign flush     = !en;
  assign mismatch  = byte_evt && byte_first && addr_mode && (byte_data != addr_value);
  assign evt_eff   = byte_evt && !drop && !mismatch;
  assign first_eff = byte_first && addr_mode;

  always_ff @(posedge clk) begin
    if (rst || flush)      drop <= 1'b0;
    else if (frame_start)  drop <= 1'b0;
    else if (mismatch)     drop <= 1'b1;
  end

  spi32_serial #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_serial (
    .clk(clk), .rst(rst), .en(en), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .tx_byte(tx_byte), .tx_mute(drop),
    .byte_evt(byte_evt), .byte_data(byte_data), .byte_first(byte_first),
    .frame_start(frame_start), .frame_end(frame_end), .miso(miso)
  );

  spi32_len #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .flush(flush), .len_en(len_en), .len_value(len_value),
    .evt(evt_eff), .frame_end(frame_end), .err_clr(len_err_clr),
    .len_hit(len_hit), .len_err(len_err)
  );

  spi32_rx_pack #(.BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .flush(flush), .evt(evt_eff), .data(byte_data),
    .first(first_eff), .store_en(rx_en), .len_hit(len_hit), .rd_ack(rd_ack),
    .rd_data(rd_data), .rd_cnt(rd_cnt), .rx_valid(rxc)
  );

  spi32_tx_unpack #(.BYTES(WORD_BYTES), .BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .flush(flush), .wr_valid(wr_valid), .wr_data(wr_data),
    .evt(evt_eff), .len_hit(len_hit), .tx_byte(tx_byte), .dre(dre), .txc(txc)
  );

  // R8: a dropped frame keeps the serial output low
  a_r8_mute: assert property (@(posedge clk) disable iff (rst)
    drop && en |=> !miso);
  // R11: disabling empties the holding register and the receive word
  a_r11_flush: assert property (@(posedge clk) disable iff (rst)
    !en |=> dre && !rxc && !txc);
  // R12: after reset the holding register is empty
  a_r12_reset_empty: assert property (@(posedge clk)
    $past(rst) |-> dre && !rxc && !txc && !len_err);
endmodule

// File: tb/test_spi32_client_packer.sv
module test_spi32_client_packer;
  localparam int H = 8;

  logic        clk = 1'b0, rst = 1'b1, en = 1'b0, rx_en = 1'b1, len_en = 1'b0;
  logic [7:0]  len_value = 8'd0, addr_value = 8'h00;
  logic        addr_mode = 1'b0, wr_valid = 1'b0, rd_ack = 1'b0, len_err_clr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic [31:0] rd_data;
  logic [2:0]  rd_cnt;
  logic        rxc, dre, txc, len_err, miso;

  always #10 clk = ~clk;

  spi32_client_packer i_spi32_client_packer (
    .clk(clk), .rst(rst), .en(en), .rx_en(rx_en), .len_en(len_en), .len_value(len_value),
    .addr_mode(addr_mode), .addr_value(addr_value), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_ack(rd_ack), .rd_data(rd_data), .rd_cnt(rd_cnt), .rxc(rxc), .dre(dre), .txc(txc),
    .len_err(len_err), .len_err_clr(len_err_clr), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .miso(miso)
  );

  int total = 0, fails = 0;
  bit done = 0;

  // bench model state
  int          m_rl = 0, m_len = 0, m_tl = 0, head = 0, tail = 0;
  logic [31:0] m_acc = '0;
  logic [31:0] q [0:7];
  bit          m_drop = 0, m_err = 0, m_txc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_flush();
    m_rl = 0; m_len = 0; m_tl = 0; head = 0; tail = 0; m_acc = '0; m_txc = 0; m_drop = 0;
  endtask

  task automatic wr_word(input logic [31:0] w);
    while (!dre) @(negedge clk);
    wr_data = w; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    q[tail % 8] = w; tail++; m_txc = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_byte(input logic [7:0] mo, input bit first);
    logic [7:0]  exp_mi, got_mi;
    logic [31:0] ew;
    int          ec, lp;
    bit          got, hit;
    got = 0; ew = '0; ec = 0;
    exp_mi = (head != tail) ? q[head % 8][m_tl*8 +: 8] : 8'h00;
    if (m_drop) begin
      exp_mi = 8'h00;
    end else if (first && addr_mode && mo != addr_value) begin
      m_drop = 1;
    end else begin
      hit = len_en && len_value != 0 && (m_len + 1 == int'(len_value));
      m_len = hit ? 0 : (len_en ? m_len + 1 : 0);
      if (rx_en) begin
        lp = (first && addr_mode) ? 0 : m_rl;
        if (first && addr_mode) m_acc = '0;
        m_acc[lp*8 +: 8] = mo;
        if (lp == 3 || hit) begin
          got = 1; ew = m_acc; ec = lp + 1; m_acc = '0; m_rl = 0;
        end else m_rl = lp + 1;
      end else if (hit) begin
        m_acc = '0; m_rl = 0;
      end
      if (head != tail) begin
        if (m_tl == 3 || hit) begin
          head++; m_tl = 0;
          if (head == tail) m_txc = 1;
        end else m_tl++;
      end
    end
    for (int i = 7; i >= 0; i--) begin
      mosi = mo[i];
      repeat (H) @(negedge clk);
      got_mi[i] = miso;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
    repeat (6) @(negedge clk);
    chk(got_mi == exp_mi, "R1 miso byte msb first", 32'(got_mi), 32'(exp_mi));
    if (got) begin
      chk(rxc == 1'b1, "R2 word ready flag", 32'(rxc), 32'd1);
      chk(rd_data == ew, ec == 4 ? "R2 word lanes" : "R3 short word lanes", rd_data, ew);
      chk(int'(rd_cnt) == ec, ec == 4 ? "R2 byte count" : "R3 short count", 32'(rd_cnt), 32'(ec));
      rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
      chk(rxc == 1'b0, "R13 ack clears rxc", 32'(rxc), 32'd0);
    end else begin
      chk(rxc == 1'b0, "R2 R7 no word yet", 32'(rxc), 32'd0);
    end
  endtask

  task automatic frame(input logic [7:0] b0, input int n, input logic [7:0] base);
    m_drop = 0;
    ss_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) do_byte(i == 0 ? b0 : base + 8'(i), i == 0);
    repeat (H) @(negedge clk);
    ss_n = 1'b1;
    repeat (8) @(negedge clk);
    if (len_en && m_len != 0) m_err = 1;
    chk(len_err == m_err, "R5 length error state", 32'(len_err), 32'(m_err));
  endtask

  // {len_en, len_value, byte count, first transmit word}
  localparam logic [48:0] VEC [5] = '{
    {1'b0, 8'd0, 8'd8, 32'h44332211},
    {1'b1, 8'd6, 8'd6, 32'hA5B6C7D8},
    {1'b1, 8'd5, 8'd5, 32'h0F1E2D3C},
    {1'b0, 8'd0, 8'd4, 32'h99887766},
    {1'b1, 8'd3, 8'd3, 32'hC0FFEE11}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(dre == 1'b1, "R12 dre after reset", 32'(dre), 32'd1);
    chk(rxc == 1'b0, "R12 rxc after reset", 32'(rxc), 32'd0);
    chk(txc == 1'b0, "R12 txc after reset", 32'(txc), 32'd0);
    chk(len_err == 1'b0, "R12 len_err after reset", 32'(len_err), 32'd0);
    chk(miso == 1'b0, "R12 miso after reset", 32'(miso), 32'd0);
    en = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R1 R2 R3 R4 R9
    for (int k = 0; k < 5; k++) begin
      len_en    = VEC[k][48];
      len_value = VEC[k][47:40];
      wr_word(VEC[k][31:0]);
      if (VEC[k][39:32] > 8'd4) wr_word(~VEC[k][31:0]);
      frame(8'h10 * 8'(k + 1), int'(VEC[k][39:32]), 8'h10 * 8'(k + 1));
      chk(txc == m_txc, "R4 R9 transmit done after frame", 32'(txc), 32'(m_txc));
    end

    // R5: length broken across frames, remainder next frame, sticky until cleared
    len_en = 1'b1; len_value = 8'd6;
    wr_word(32'h87654321);
    frame(8'hA0, 3, 8'hA0);
    chk(len_err == 1'b1, "R5 error raised", 32'(len_err), 32'd1);
    frame(8'hB0, 3, 8'hB0);
    chk(len_err == 1'b1, "R5 error sticky", 32'(len_err), 32'd1);
    len_err_clr = 1'b1; @(negedge clk); len_err_clr = 1'b0; m_err = 0;
    @(negedge clk);
    chk(len_err == 1'b0, "R5 error cleared", 32'(len_err), 32'd0);

    // R6: no length, partial word carries to the next frame
    len_en = 1'b0;
    frame(8'hC1, 2, 8'hC1);
    frame(8'hD1, 2, 8'hD1);

    // R7: receiver off, length still counts
    rx_en = 1'b0; len_en = 1'b1; len_value = 8'd2;
    frame(8'h31, 3, 8'h31);
    chk(len_err == 1'b1, "R7 length counted without receiver", 32'(len_err), 32'd1);
    len_err_clr = 1'b1; @(negedge clk); len_err_clr = 1'b0; m_err = 0;
    frame(8'h41, 1, 8'h41);
    chk(len_err == 1'b0, "R7 length completed", 32'(len_err), 32'd0);
    rx_en = 1'b1; len_en = 1'b0;

    // R8: address match, mismatch frame dropped, match discards partial
    addr_mode = 1'b1; addr_value = 8'h5A;
    frame(8'h5A, 6, 8'h00);
    frame(8'h33, 3, 8'h60);
    frame(8'h5A, 4, 8'h06);
    addr_mode = 1'b0;

    // R10: underrun sends zero bytes
    frame(8'h71, 4, 8'h71);

    // R9: holding register flags
    wr_word(32'h0BADF00D);
    chk(dre == 1'b1, "R9 dre high after load", 32'(dre), 32'd1);
    wr_word(32'h12345678);
    chk(dre == 1'b0, "R9 dre low while held", 32'(dre), 32'd0);
    wr_valid = 1'b1; wr_data = 32'hFFFFFFFF; @(negedge clk); wr_valid = 1'b0;
    frame(8'h81, 4, 8'h81);
    chk(dre == 1'b1, "R9 dre after hold moves", 32'(dre), 32'd1);

    // R11: disable flushes a held word and a partial receive word
    wr_word(32'h55AA55AA);
    frame(8'h91, 2, 8'h91);
    en = 1'b0; repeat (3) @(negedge clk); en = 1'b1; model_flush();
    repeat (3) @(negedge clk);
    chk(dre == 1'b1 && txc == 1'b0, "R11 flush clears transmit", 32'({dre, txc}), 32'b10);
    frame(8'hE1, 4, 8'hE1);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule